// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

A register-mapped pin controller with four banks of sixteen pins. Each pin can be set as an input or as a driven output. As an input it can also raise an interrupt. The trigger for each pin is chosen by three per-bank bitmaps, which select edge or level detection and the active polarity. Pin levels pass through a two-stage synchronizer. The synchronized level feeds the readable status, and it is also compared against the trigger settings. Each detected event sets a per-pin pending bit, which software clears by writing to the bank's pending register.

A summary register gathers one flag per bank (any pending pin that is not masked) and a set of extra interrupt sources from outside the GPIO banks. A top mask register enables each extra source and holds a global enable. The single host interrupt line is registered. Both-edge detection is left to software, which flips a pin's edge polarity after each event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction, output, trigger-type, edge-polarity, level-polarity, pending and top mask read as 0, every bank mask reads 0xFFFF, and `irq` is 0.
- R2: Word address `bank*16 + offset` selects a bank register. The offsets are 0 direction, 1 output, 2 pin status (read only), 3 mask, 4 trigger type, 5 edge polarity, 6 level polarity and 7 pending. Address 64 is the summary (read only) and address 65 is the top mask. Writable registers read back what was written.
- R3: `pin_oe` bit `bank*16+pin` equals that bank's direction bit, where 1 means output. `pin_out` carries the output register bit.
- R4: The status register returns pin levels seen through a two-flop synchronizer. A pin change made before clock edge k is readable after edge k+1.
- R5: A trigger-type bit of 1 selects edge mode. In edge mode an edge-polarity bit of 1 captures rising transitions and 0 captures falling transitions into the pending bit. The other direction leaves it unchanged.
- R6: A trigger-type bit of 0 selects level mode. In level mode a level-polarity bit of 1 is active-high and 0 is active-low. The pending bit is set on every cycle the active level is present, so it returns after a clear while that level persists.
- R7: A bank mask bit of 1 stops that pin from setting its pending bit. Summary bit n (n = 0..3) is 1 when bank n has a pending bit whose mask bit is 0.
- R8: A write to a pending register clears the bits written as 0 and keeps the bits written as 1. An event in the same cycle wins over the clear. Pending bits never drop without a write.
- R9: Summary bits 4 to 9 show the extra sources `ext_irq[0..5]` after one register stage. Top mask bits 4 to 9 enable those sources (1 means enabled), and top mask bit 15 is the global enable.
- R10: `irq` is a register holding: global enable AND (any bank summary bit OR any enabled extra-source bit). It follows that condition one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the read strobe |
| pin_in | input | 64 | Raw pin levels |
| pin_out | output | 64 | Driven pin values |
| pin_oe | output | 64 | Pin output enables |
| ext_irq | input | 6 | Extra interrupt sources (level) |
| irq | output | 1 | Host interrupt |

## Verification
Random register traffic, with a shadow copy kept in the bench, checks that the address map decodes and stores correctly and that the pin drive follows it. Random pin words check that the status path carries each bit of every bank with the synchronizer delay. Directed pin sequences then drive one pin at a time through the rising, falling, active-high and active-low settings. These separate the two edge directions from each other and from level behaviour, and show whether a cleared level pin reasserts. Masked pins, partial clears and the extra sources with and without their enables show which gate blocks which path to the interrupt line.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NBANKS = 4,
  parameter int NPINS  = 16,
  parameter int NEXT   = 6,
  parameter int DW     = 16,
  parameter int AW     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic [NBANKS*NPINS-1:0]   pin_in,
  output logic [NBANKS*NPINS-1:0]   pin_out,
  output logic [NBANKS*NPINS-1:0]   pin_oe,
  input  logic [NEXT-1:0]           ext_irq,
  output logic                      irq
);
  localparam int NP    = NBANKS * NPINS;
  localparam int BW    = AW - 4;
  localparam int SUMW  = NBANKS + NEXT;
  localparam logic [AW-1:0] SUM_A = AW'(NBANKS * 16);
  localparam logic [AW-1:0] TOP_A = AW'(NBANKS * 16 + 1);

  logic [NP-1:0] dir_r, out_r, msk_r, trg_r, epl_r, lpl_r, pnd_r;
  logic [NP-1:0] s1, s2, s3, keep, ev;
  logic [NEXT-1:0] ext_q, ext_en;
  logic gen_r, irq_q;
  logic [NBANKS-1:0] bank_sum;
  logic [SUMW-1:0] summ;

  wire wr_en   = bus_sel && bus_wr;
  wire in_bank = bus_addr < SUM_A;
  wire [BW-1:0] bidx = bus_addr[AW-1:4];
  wire [3:0] off = bus_addr[3:0];

  assign pin_oe  = dir_r;
  assign pin_out = out_r;

  wire [NP-1:0] rise = s2 & ~s3;
  wire [NP-1:0] fall = ~s2 & s3;
  wire [NP-1:0] edge_hit = (epl_r & rise) | (~epl_r & fall);
  wire [NP-1:0] lvl_hit  = ~(s2 ^ lpl_r);
  assign ev = ~msk_r & ((trg_r & edge_hit) | (~trg_r & lvl_hit));

  genvar b;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_bank
      wire hit = wr_en && in_bank && (bidx == BW'(b));
      assign keep[b*NPINS +: NPINS] = (hit && off == 4'd7) ? bus_wdata[NPINS-1:0] : '1;
      assign bank_sum[b] = |(pnd_r[b*NPINS +: NPINS] & ~msk_r[b*NPINS +: NPINS]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dir_r[b*NPINS +: NPINS] <= '0;
          out_r[b*NPINS +: NPINS] <= '0;
          msk_r[b*NPINS +: NPINS] <= '1;
          trg_r[b*NPINS +: NPINS] <= '0;
          epl_r[b*NPINS +: NPINS] <= '0;
          lpl_r[b*NPINS +: NPINS] <= '0;
        end else if (hit) begin
          case (off)
            4'd0: dir_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            4'd1: out_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            4'd3: msk_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            4'd4: trg_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            4'd5: epl_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            4'd6: lpl_r[b*NPINS +: NPINS] <= bus_wdata[NPINS-1:0];
            default: ;
          endcase
        end
      end
    end
  endgenerate

  assign summ = {ext_q, bank_sum};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      pnd_r <= '0;
      ext_q <= '0; ext_en <= '0; gen_r <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
      pnd_r <= (pnd_r & keep) | ev;
      ext_q <= ext_irq;
      if (wr_en && bus_addr == TOP_A) begin
        ext_en <= bus_wdata[NBANKS +: NEXT];
        gen_r  <= bus_wdata[DW-1];
      end
      irq_q <= gen_r && ((|bank_sum) || (|(ext_q & ext_en)));
    end
  end

  assign irq = irq_q;

  logic [DW-1:0] rd_v, top_v;
  always_comb begin
    top_v = '0;
    top_v[DW-1] = gen_r;
    top_v[NBANKS +: NEXT] = ext_en;
    rd_v = '0;
    if (in_bank) begin
      case (off)
        4'd0: rd_v = DW'(dir_r[bidx*NPINS +: NPINS]);
        4'd1: rd_v = DW'(out_r[bidx*NPINS +: NPINS]);
        4'd2: rd_v = DW'(s2[bidx*NPINS +: NPINS]);
        4'd3: rd_v = DW'(msk_r[bidx*NPINS +: NPINS]);
        4'd4: rd_v = DW'(trg_r[bidx*NPINS +: NPINS]);
        4'd5: rd_v = DW'(epl_r[bidx*NPINS +: NPINS]);
        4'd6: rd_v = DW'(lpl_r[bidx*NPINS +: NPINS]);
        4'd7: rd_v = DW'(pnd_r[bidx*NPINS +: NPINS]);
        default: rd_v = '0;
      endcase
    end else if (bus_addr == SUM_A) begin
      rd_v = DW'(summ);
    end else if (bus_addr == TOP_A) begin
      rd_v = top_v;
    end
  end
  assign bus_rdata = (bus_sel && !bus_wr) ? rd_v : '0;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NP    = 64,
  parameter int NPINS = 16,
  parameter int SUMW  = 10,
  parameter int DW    = 16,
  parameter int AW    = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NP-1:0]   pnd_r,
  input logic [NP-1:0]   msk_r,
  input logic [NP-1:0]   ev,
  input logic [SUMW-1:0] summ,
  input logic            gen_r,
  input logic            irq
);
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(|summ)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !$past(gen_r) |-> !irq); // R9
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (pnd_r & ~$past(pnd_r) & $past(msk_r)) == '0); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(bus_sel && bus_wr) |-> ((~pnd_r & $past(pnd_r)) == '0)); // R8
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel && bus_wr && bus_addr == AW'(7) && bus_wdata[NPINS-1:0] == '0 && ev[NPINS-1:0] == '0) |=> (pnd_r[NPINS-1:0] == '0)); // R8
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NP(NBANKS*NPINS), .NPINS(NPINS), .SUMW(NBANKS+NEXT), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pnd_r(pnd_r), .msk_r(msk_r),
  .ev(ev), .summ(summ), .gen_r(gen_r), .irq(irq)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [6:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [63:0] pin_in = '0, pin_out, pin_oe;
  logic [5:0] ext_irq = '0;
  logic irq;
  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] shd [0:127];

  always #5 clk = ~clk;

  gpio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ext_irq(ext_irq), .irq(irq));

  function automatic logic [6:0] ra(int b, int o);
    return 7'(b * 16 + o);
  endfunction

  function automatic logic [63:0] exp_vec(int o);
    logic [63:0] v;
    for (int b = 0; b < 4; b++) v[b*16 +: 16] = shd[b*16 + o];
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic setpin(int idx, logic v);
    @(negedge clk); pin_in[idx] = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic quiet(int b);
    wr(ra(b, 3), 16'hFFFF);
    wr(ra(b, 7), 16'h0000);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(ra(0, 0), d); chk("R1 dir", d, 16'h0);
    rd(ra(2, 3), d); chk("R1 mask", d, 16'hFFFF);
    rd(ra(3, 7), d); chk("R1 pend", d, 16'h0);
    rd(7'd65, d);    chk("R1 topmask", d, 16'h0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", pin_oe, 64'h0);

    // R2/R3 random register traffic against shadow
    for (int i = 0; i < 128; i++) shd[i] = 16'h0;
    for (int b = 0; b < 4; b++) shd[b*16 + 3] = 16'hFFFF;
    for (int i = 0; i < 40; i++) begin
      int b = $urandom % 4;
      int o;
      logic [15:0] v = 16'($urandom);
      case ($urandom % 6) 0: o = 0; 1: o = 1; 2: o = 3; 3: o = 4; 4: o = 5; default: o = 6; endcase
      wr(ra(b, o), v);
      shd[b*16 + o] = v;
      rd(ra(b, o), d); chk("R2 readback", d, v);
    end
    rd(7'd90, d); chk("R2 unmapped", d, 16'h0);
    chk("R3 oe", pin_oe, exp_vec(0));
    chk("R3 out", pin_out, exp_vec(1));
    for (int b = 0; b < 4; b++) begin
      wr(ra(b, 3), 16'hFFFF);
      for (int o = 0; o < 7; o++) if (o != 2 && o != 3) wr(ra(b, o), 16'h0);
      wr(ra(b, 7), 16'h0);
    end
    chk("R3 oe cleared", pin_oe, 64'h0);

    // R4 status through synchronizer
    for (int i = 0; i < 6; i++) begin
      logic [63:0] p = {32'($urandom), 32'($urandom)};
      @(negedge clk) pin_in = p;
      @(posedge clk); @(posedge clk);
      for (int b = 0; b < 4; b++) begin
        rd(ra(b, 2), d); chk("R4 status", d, p[b*16 +: 16]);
      end
    end
    @(negedge clk) pin_in = '0;
    repeat (4) @(posedge clk);

    // R5 rising edge, bank1 pin3
    wr(ra(1, 4), 16'h0008); wr(ra(1, 5), 16'h0008); wr(ra(1, 3), 16'hFFF7); wr(ra(1, 7), 0);
    setpin(19, 1);
    rd(ra(1, 7), d); chk("R5 rising pend", d, 16'h0008);
    rd(7'd64, d);    chk("R7 summary bank1", d, 16'h0002);
    chk("R10 irq off without global", irq, 0);
    wr(7'd65, 16'h8000);
    @(negedge clk); chk("R10 irq on", irq, 1);
    wr(ra(1, 7), 16'h0);
    @(negedge clk); chk("R10 irq drops", irq, 0);
    setpin(19, 0);
    rd(ra(1, 7), d); chk("R5 falling ignored in rising mode", d, 16'h0);
    // R5 falling
    wr(ra(1, 5), 16'h0000);
    setpin(19, 1);
    rd(ra(1, 7), d); chk("R5 rising ignored in falling mode", d, 16'h0);
    setpin(19, 0);
    rd(ra(1, 7), d); chk("R5 falling pend", d, 16'h0008);
    quiet(1);

    // R6 level high, bank2 pin0
    wr(ra(2, 4), 0); wr(ra(2, 6), 16'h0001); wr(ra(2, 3), 16'hFFFE); wr(ra(2, 7), 0);
    rd(ra(2, 7), d); chk("R6 inactive level", d, 16'h0);
    setpin(32, 1);
    rd(ra(2, 7), d); chk("R6 high pend", d, 16'h0001);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d); chk("R6 reassert after clear", d, 16'h0001);
    setpin(32, 0);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d); chk("R6 stays clear when inactive", d, 16'h0);
    wr(ra(2, 6), 16'h0000);
    @(negedge clk);
    rd(ra(2, 7), d); chk("R6 low level pend", d, 16'h0001);
    quiet(2);
    @(negedge clk); chk("R10 irq idle", irq, 0);

    // R7 masked pin, bank3 pin5
    wr(ra(3, 4), 16'h0020); wr(ra(3, 5), 16'h0020);
    setpin(53, 1);
    rd(ra(3, 7), d); chk("R7 masked no pend", d, 16'h0);
    setpin(53, 0);

    // R8 partial clear, bank0 pins 1,2
    wr(ra(0, 4), 16'h0006); wr(ra(0, 5), 16'h0006); wr(ra(0, 3), 16'hFFF9); wr(ra(0, 7), 0);
    setpin(1, 1); setpin(2, 1);
    rd(ra(0, 7), d); chk("R8 both pending", d, 16'h0006);
    wr(ra(0, 7), 16'h0002);
    rd(ra(0, 7), d); chk("R8 partial clear", d, 16'h0002);
    wr(ra(0, 7), 16'h0000);
    rd(ra(0, 7), d); chk("R8 full clear", d, 16'h0);
    quiet(0);
    @(negedge clk); pin_in = '0;
    repeat (4) @(posedge clk);

    // R9 extra sources
    @(negedge clk) ext_irq = 6'b000010;
    @(negedge clk);
    rd(7'd64, d); chk("R9 summary ext bit5", d, 16'h0020);
    @(negedge clk); chk("R9 disabled source", irq, 0);
    wr(7'd65, 16'h8020);
    rd(7'd65, d); chk("R9 topmask readback", d, 16'h8020);
    @(negedge clk); chk("R9 enabled source", irq, 1);
    wr(7'd65, 16'h0020);
    @(negedge clk); chk("R9 global off", irq, 0);
    @(negedge clk) ext_irq = '0;

    finish_run();
  end
endmodule